// File: doc/BRIEF.md
# Serial Transmitter with Break Character Generation

This block is the transmit half of an asynchronous serial port that sends 8N1 frames and can also send the long all-low break character used to open a LIN frame header. A one-entry holding buffer sits in front of a shift register. Software-side logic writes a byte with a strobe. On the next baud tick, if the shift register is free or is finishing its stop bit, the byte moves into the shift register. Baud ticks come from an external rate generator, and every serial bit lasts exactly one tick period.

A break is requested by setting an internal break flag through a one-cycle set pulse. The flag is then armed by the next byte write, whose data value is discarded. The shift register looks at the flag only when it loads. If the flag is set at that moment, the load produces a break frame instead of a data frame: one start bit, twelve further low bit times, then a high stop bit. Hardware clears the flag at the tick that ends the break's stop bit. The sync byte, typically 0x55, can therefore be written into the holding buffer while the break is still shifting, and it goes out as an ordinary data frame with no idle gap.

Top module: `uart_brk_tx`

## Requirements
- R1: After a synchronous active-low reset, the TX line is high, the buffer-empty flag is 1, the shifter-idle flag is 1 and the break flag is 0.
- R2: A data frame is a low start bit, 8 data bits least significant bit first, then a high stop bit. Each bit holds for exactly one baud tick period. The start bit appears in the cycle after the tick that loads the byte.
- R3: A frame loaded while the break flag is set drives 13 consecutive low bit times (the start bit plus twelve), then one high stop bit, whatever data was written.
- R4: The break flag stays set for the whole break frame. It clears in the cycle after the tick that ends the break stop bit.
- R5: A byte written while a break is shifting is loaded on the tick that ends the break stop bit and is sent as a normal data frame, with its start bit directly after the break stop bit.
- R6: The shifter-idle flag is 0 from the cycle after a load until the cycle after the tick that ends the last frame's stop bit, for both frame kinds. It is 1 otherwise.
- R7: An accepted write makes the buffer-empty flag 0 in the next cycle. The flag returns to 1 in the cycle after the byte moves into the shift register.
- R8: A write while the holding buffer is full is dropped, and the buffered byte is unaffected.
- R9: Setting the break flag while a data frame is shifting does not change that frame. The flag stays set and applies to the next load.
- R10: While transmit enable is low, the TX line is high and no byte is loaded. Dropping enable mid-frame aborts the frame, and the shifter goes idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmit enable |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | DATA_W | Byte to send (ignored for a break) |
| brk_set | input | 1 | One-cycle pulse that sets the break flag |
| tx_line | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer can take a byte |
| shift_idle | output | 1 | Shift register holds no frame |
| brk_flag | output | 1 | Break request pending; cleared by hardware |

## Verification
The bound checker watches, on every cycle, that the shifter only starts on an enabled tick and drops out when enable falls. It also checks that a break stays low until its stop bit, that the break flag only falls at the tick ending a break stop bit, and that the buffer-empty flag responds to writes and only drains on a tick. Only the bench scenarios can show that the bit values and their exact durations are right. That covers an exhaustive sweep of all 256 data bytes, the break followed directly by the queued sync byte, a dropped write to a full buffer, a break request raised during a data frame, and an aborted frame.

// File: rtl/uart_brk_pkg.sv
// Shared types and sizing helpers for the break-capable serial transmitter.
// Assumes: frame lengths are small positive integers.
package uart_brk_pkg;

    // Kind of frame currently held in the shift register
    typedef enum logic {
        KIND_DATA  = 1'b0,
        KIND_BREAK = 1'b1
    } frame_kind_e;

    // Longest frame in bit times: start + payload + stop for either kind
    function automatic int frame_max(input int data_w, input int brk_low);
        int d;
        int b;
        d = data_w + 2;
        b = brk_low + 2;
        return (d > b) ? d : b;
    endfunction

endpackage

// File: rtl/uart_brk_hold.sv
// One-entry holding buffer in front of the shift register.
// Accepts a write only when empty; a write while full is discarded.
// Assumes: take is asserted only while full, so write and take never coincide.
module uart_brk_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    // Occupancy and content of the single buffer entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_stb && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

endmodule

// File: rtl/uart_brk_flag.sv
// Break request flag: set by a pulse, cleared when a break frame completes.
// A set pulse in the same cycle as completion wins.
// Assumes: done only pulses on the tick that ends a break stop bit.
module uart_brk_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic done,
    output logic flag
);

    // Set-dominant flag register with hardware clear
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (set)  flag <= 1'b1;
        else if (done) flag <= 1'b0;
    end

endmodule

// File: rtl/uart_brk_shift.sv
// Transmit shift register. A load builds either a data frame image
// (start, payload LSB first, stop) or a break image (BRK_LOW+1 low bits
// and a stop bit). It shifts one bit per baud tick, filling with ones.
// Assumes: load is asserted only on a baud tick while enabled.
module uart_brk_shift
    import uart_brk_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BRK_LOW = 12,
    parameter int SH_W    = 14,
    parameter int CNT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              baud_tick,
    input  logic              load,
    input  frame_kind_e       load_kind,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              last_bit,
    output frame_kind_e       cur_kind,
    output logic [CNT_W-1:0]  bits_left,
    output logic              ser_out
);

    localparam int DATA_LEN = DATA_W + 2;
    localparam int BRK_LEN  = BRK_LOW + 2;

    logic [SH_W-1:0] sh_q;
    logic [SH_W-1:0] data_img;
    logic [SH_W-1:0] brk_img;

    // Frame images, one bit position at a time
    for (genvar gi = 0; gi < SH_W; gi++) begin : g_img
        if (gi == 0) begin : g_start
            assign data_img[gi] = 1'b0;
        end else if (gi <= DATA_W) begin : g_pay
            assign data_img[gi] = load_data[gi-1];
        end else begin : g_pad
            assign data_img[gi] = 1'b1;
        end
        assign brk_img[gi] = (gi >= BRK_LEN - 1);
    end

    // Frame state: image, remaining bit count and kind
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            busy      <= 1'b0;
            sh_q      <= '1;
            bits_left <= '0;
            cur_kind  <= KIND_DATA;
        end else if (load) begin
            busy      <= 1'b1;
            cur_kind  <= load_kind;
            sh_q      <= (load_kind == KIND_BREAK) ? brk_img : data_img;
            bits_left <= (load_kind == KIND_BREAK) ? CNT_W'(BRK_LEN) : CNT_W'(DATA_LEN);
        end else if (busy && baud_tick) begin
            busy      <= (bits_left != CNT_W'(1));
            sh_q      <= {1'b1, sh_q[SH_W-1:1]};
            bits_left <= bits_left - CNT_W'(1);
        end
    end

    // Current bit: frame bit when busy, line idle level otherwise
    assign ser_out  = sh_q[0] | ~busy;
    assign last_bit = busy && (bits_left == CNT_W'(1));

endmodule

// File: rtl/uart_brk_tx.sv
// Serial transmitter top: holding buffer, break flag and shift register.
// A byte moves to the shifter on a baud tick while enabled, if the shifter
// is idle or finishing its stop bit. The frame kind is taken from the break
// flag at that moment, ignoring a flag that this same tick clears.
// Assumes: baud_tick is a one-cycle pulse; all inputs are synchronous to clk.
module uart_brk_tx
    import uart_brk_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BRK_LOW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              brk_set,
    output logic              tx_line,
    output logic              buf_empty,
    output logic              shift_idle,
    output logic              brk_flag
);

    localparam int SH_W  = frame_max(DATA_W, BRK_LOW);
    localparam int CNT_W = $clog2(SH_W + 1);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              busy;
    logic              last_bit;
    frame_kind_e       cur_kind;
    logic [CNT_W-1:0]  bits_left;
    logic              ser_out;
    logic              brk_done;
    logic              cur_brk;
    frame_kind_e       load_kind;

    // Transfer and break-completion decisions for this tick
    always_comb begin
        cur_brk   = (cur_kind == KIND_BREAK);
        brk_done  = baud_tick && tx_en && last_bit && cur_brk;
        take      = baud_tick && tx_en && hold_full && (!busy || last_bit);
        load_kind = (brk_flag && !brk_done) ? KIND_BREAK : KIND_DATA;
    end

    uart_brk_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_brk_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (brk_set),
        .done  (brk_done),
        .flag  (brk_flag)
    );

    uart_brk_shift #(
        .DATA_W  (DATA_W),
        .BRK_LOW (BRK_LOW),
        .SH_W    (SH_W),
        .CNT_W   (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .baud_tick (baud_tick),
        .load      (take),
        .load_kind (load_kind),
        .load_data (hold_data),
        .busy      (busy),
        .last_bit  (last_bit),
        .cur_kind  (cur_kind),
        .bits_left (bits_left),
        .ser_out   (ser_out)
    );

    // Output drive: line forced high when disabled
    assign tx_line    = ser_out | ~tx_en;
    assign buf_empty  = ~hold_full;
    assign shift_idle = ~busy;

endmodule

// File: rtl/uart_brk_tx_chk.sv
// Cycle-level checker for uart_brk_tx, attached by bind.
// Assumes: the same clock and reset as the transmitter.
module uart_brk_tx_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             baud_tick,
    input logic             tx_en,
    input logic             wr_stb,
    input logic             tx_line,
    input logic             buf_empty,
    input logic             shift_idle,
    input logic             brk_flag,
    input logic             cur_brk,
    input logic [CNT_W-1:0] bits_left
);

    // R2
    start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_idle) |-> ($past(baud_tick) && $past(tx_en)));

    // R10
    abort_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> shift_idle);

    // R3
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_idle && cur_brk && bits_left > CNT_W'(1)) |-> !tx_line);

    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_flag) |-> ($past(baud_tick) && $past(cur_brk) && $past(bits_left) == CNT_W'(1)));

    // R7
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_empty && wr_stb) |=> !buf_empty);

    // R7
    drain_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_empty && !baud_tick) |=> !buf_empty);

endmodule

bind uart_brk_tx uart_brk_tx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .tx_en      (tx_en),
    .wr_stb     (wr_stb),
    .tx_line    (tx_line),
    .buf_empty  (buf_empty),
    .shift_idle (shift_idle),
    .brk_flag   (brk_flag),
    .cur_brk    (cur_brk),
    .bits_left  (bits_left)
);

// File: tb/sim_uart_brk_tx.sv
// Bench for uart_brk_tx: baud tick every 4 cycles, driven by the stimulus tasks.
module sim_uart_brk_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       brk_set = 1'b0;
    logic       tx_line;
    logic       buf_empty;
    logic       shift_idle;
    logic       brk_flag;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    uart_brk_tx u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .tx_en      (tx_en),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .brk_set    (brk_set),
        .tx_line    (tx_line),
        .buf_empty  (buf_empty),
        .shift_idle (shift_idle),
        .brk_flag   (brk_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, pass the edge, settle 2 ns after it
    task automatic clk1(input logic tick, input logic stb, input logic [7:0] d, input logic set);
        baud_tick = tick;
        wr_stb    = stb;
        wr_data   = d;
        brk_set   = set;
        @(posedge clk);
        #2;
        baud_tick = 1'b0;
        wr_stb    = 1'b0;
        brk_set   = 1'b0;
    endtask

    function automatic logic [13:0] data_img(input logic [7:0] d);
        return {4'b1111, 1'b1, d, 1'b0};
    endfunction

    // Check a frame bit by bit, four cycles per bit; the final tick ends it
    task automatic run_frame(input string req, input logic [13:0] bits, input int len,
                             input int wr_at, input logic [7:0] wd,
                             input int set_at, input int flag_exp);
        for (int i = 0; i < len; i++) begin
            for (int c = 0; c < 4; c++) begin
                chk(req, int'(tx_line), int'(bits[i]));
                chk("R6", int'(shift_idle), 0);
                if (flag_exp >= 0) chk("R4", int'(brk_flag), flag_exp);
                if (c < 3) clk1(1'b0, (i == wr_at) && (c == 0), wd, (i == set_at) && (c == 0));
                else       clk1(1'b1, 1'b0, 8'h00, 1'b0);
            end
        end
    endtask

    // Main stimulus
    initial begin
        repeat (3) clk1(1'b0, 1'b0, 8'h00, 1'b0);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", int'(tx_line), 1);
        chk("R1", int'(buf_empty), 1);
        chk("R1", int'(shift_idle), 1);
        chk("R1", int'(brk_flag), 0);

        // R2 exhaustive data sweep
        tx_en = 1'b1;
        for (int b = 0; b < 256; b++) begin
            clk1(1'b0, 1'b1, 8'(b), 1'b0);
            chk("R7", int'(buf_empty), 0);
            clk1(1'b1, 1'b0, 8'h00, 1'b0);
            chk("R7", int'(buf_empty), 1);
            run_frame("R2", data_img(8'(b)), 10, -1, 8'h00, -1, 0);
            chk("R6", int'(shift_idle), 1);
            chk("R2", int'(tx_line), 1);
        end

        // R3/R4/R5 break with dummy data, sync byte queued during it
        clk1(1'b0, 1'b0, 8'h00, 1'b1);
        chk("R4", int'(brk_flag), 1);
        clk1(1'b0, 1'b1, 8'hA3, 1'b0);
        clk1(1'b1, 1'b0, 8'h00, 1'b0);
        run_frame("R3", 14'h2000, 14, 2, 8'h55, -1, 1);
        chk("R4", int'(brk_flag), 0);
        chk("R5", int'(buf_empty), 1);
        run_frame("R5", data_img(8'h55), 10, -1, 8'h00, -1, 0);
        chk("R6", int'(shift_idle), 1);

        // R9 break request during a data frame
        clk1(1'b0, 1'b1, 8'h3C, 1'b0);
        clk1(1'b1, 1'b0, 8'h00, 1'b0);
        run_frame("R9", data_img(8'h3C), 10, -1, 8'h00, 4, -1);
        chk("R9", int'(brk_flag), 1);
        clk1(1'b0, 1'b1, 8'hFF, 1'b0);
        clk1(1'b1, 1'b0, 8'h00, 1'b0);
        run_frame("R9", 14'h2000, 14, -1, 8'h00, -1, 1);
        chk("R4", int'(brk_flag), 0);
        chk("R6", int'(shift_idle), 1);

        // R8/R10 disabled: buffered byte waits, second write dropped
        tx_en = 1'b0;
        clk1(1'b0, 1'b1, 8'h0F, 1'b0);
        for (int k = 0; k < 8; k++) begin
            clk1(k % 4 == 0, 1'b0, 8'h00, 1'b0);
            chk("R10", int'(tx_line), 1);
            chk("R10", int'(buf_empty), 0);
            chk("R10", int'(shift_idle), 1);
        end
        clk1(1'b0, 1'b1, 8'hF0, 1'b0);
        tx_en = 1'b1;
        clk1(1'b1, 1'b0, 8'h00, 1'b0);
        run_frame("R8", data_img(8'h0F), 10, -1, 8'h00, -1, 0);
        for (int k = 0; k < 8; k++) begin
            chk("R8", int'(tx_line), 1);
            chk("R8", int'(shift_idle), 1);
            chk("R8", int'(buf_empty), 1);
            clk1(k % 4 == 3, 1'b0, 8'h00, 1'b0);
        end

        // R10 abort mid-frame
        clk1(1'b0, 1'b1, 8'h00, 1'b0);
        clk1(1'b1, 1'b0, 8'h00, 1'b0);
        clk1(1'b0, 1'b0, 8'h00, 1'b0);
        chk("R10", int'(tx_line), 0);
        tx_en = 1'b0;
        #1;
        chk("R10", int'(tx_line), 1);
        clk1(1'b0, 1'b0, 8'h00, 1'b0);
        chk("R10", int'(shift_idle), 1);
        tx_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            clk1(k % 4 == 0, 1'b0, 8'h00, 1'b0);
            chk("R10", int'(tx_line), 1);
            chk("R10", int'(shift_idle), 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule